// File: doc/BRIEF.md
# SMBus Block-Access Configuration Register Slave

This block is an SMBus slave that holds a bank of seven 8-bit configuration registers. The rest of the chip sees their contents as a parallel output bus. A host programs the bank with a simplified block write: the device address, then a command byte and a count byte (both acknowledged and thrown away), then data bytes. The data bytes always fill the registers from register 0 upward. A host reads the bank back with a block read. It sends the device address with the read bit set, and the slave answers with a byte count followed by every register in ascending order.

SCL and SDA arrive as plain inputs that carry the wired bus level. The slave drives SDA only through an output enable that pulls the line low. Both lines pass through a two-flop synchronizer and are sampled by a system clock at least 16 times faster than SCL. Start and stop are recognised as SDA edges while SCL is high. A start at any point restarts the transfer.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and the address byte 0xD3 (read), and leaves SDA released in the acknowledge slot for any other address byte.
- R2: In a write, the first two bytes after the address are acknowledged, and their values change no register.
- R3: Write data bytes are acknowledged one at a time and land in registers 0, 1, 2 and upward in arrival order. Register i appears on bits [8i+7:8i] of the parallel output.
- R4: A stop after any complete data byte keeps the registers already received and leaves every later register at its previous value.
- R5: Data bytes beyond the last register are still acknowledged, are discarded, and never wrap around to register 0.
- R6: A read returns the byte count 7 first, then registers 0 through 6, each sent MSB first.
- R7: A NACK from the host after any read byte ends the transmission: SDA stays released until the next start.
- R8: After reset, register i holds the value 0x11 multiplied by (i+1).
- R9: A start that arrives in the middle of a transfer abandons it, and the following address byte is decoded afresh.
- R10: The slave changes its SDA drive only while SCL is low, and its parallel outputs change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | Pulls SDA low when high |
| cfg_o | output | 56 | Parallel register contents, register i at bits [8i+7:8i] |

## Verification
The bench sweeps the address byte across the neighbourhood of the device address, so that the two valid directions are told apart from addresses that differ only in the low bits. It then runs writes of every length from zero to nine data bytes, with distinct command, count and data values, and reads the whole bank back after each one. Those lengths separate a discarded header, a partial fill, a full fill and saturation. Two further sequences cover the remaining cases: a read cut short by a NACK, where the bench clocks on and expects released SDA, and a write interrupted by a repeated start into a read.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int NREG = 7,
  parameter logic [6:0] DEV = 7'h69,
  parameter logic [NREG*8-1:0] RST_VAL = 56'h77665544332211
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int IW = $clog2(NREG + 3);
  localparam logic [IW-1:0] WLIM = IW'(NREG + 2);
  localparam logic [IW-1:0] RLIM = IW'(NREG);

  typedef enum logic [2:0] {IDLE, RX, ACK, TX, RACK} st_t;

  logic [2:0] scl_q, sda_q;
  logic scl_s, sda_s, scl_p, sda_p;
  logic start_det, stop_det, scl_rise, scl_fall;
  st_t st;
  logic addr_ph, rd, nack;
  logic [3:0] cnt;
  logic [7:0] sr, txsr, rdata;
  logic [IW-1:0] widx, ridx, wsel;
  logic wen;
  logic [7:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  assign scl_s = scl_q[1];
  assign scl_p = scl_q[2];
  assign sda_s = sda_q[1];
  assign sda_p = sda_q[2];
  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
  assign scl_rise  = scl_s && !scl_p;
  assign scl_fall  = !scl_s && scl_p;

  assign wsel = widx - IW'(2);
  assign wen  = !start_det && !stop_det && st == RX && scl_fall && cnt == 4'd8 &&
                !addr_ph && widx >= IW'(2) && widx < WLIM;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= IDLE;
      addr_ph <= 1'b0;
      rd      <= 1'b0;
      nack    <= 1'b1;
      cnt     <= '0;
      sr      <= '0;
      txsr    <= 8'hFF;
      widx    <= '0;
      ridx    <= '0;
    end else if (start_det) begin
      st      <= RX;
      addr_ph <= 1'b1;
      rd      <= 1'b0;
      cnt     <= '0;
      widx    <= '0;
      ridx    <= '0;
    end else if (stop_det) begin
      st <= IDLE;
    end else begin
      case (st)
        RX: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (addr_ph) begin
              addr_ph <= 1'b0;
              if (sr[7:1] == DEV) begin
                st <= ACK;
                rd <= sr[0];
              end else begin
                st <= IDLE;
              end
            end else begin
              st <= ACK;
              if (widx < WLIM) widx <= widx + IW'(1);
            end
          end
        end
        ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rd) begin
              st   <= TX;
              txsr <= 8'(NREG);
              ridx <= '0;
            end else begin
              st <= RX;
            end
          end
        end
        TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              st <= RACK;
            end else begin
              txsr <= {txsr[6:0], 1'b1};
              cnt  <= cnt + 4'd1;
            end
          end
        end
        RACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack || ridx >= RLIM) begin
              st <= IDLE;
            end else begin
              st   <= TX;
              txsr <= rdata;
              ridx <= ridx + IW'(1);
              cnt  <= '0;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= RST_VAL[8*i +: 8];
    end else if (wen) begin
      for (int i = 0; i < NREG; i++)
        if (wsel == IW'(i)) regs[i] <= sr;
    end

  always_comb begin
    rdata = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (ridx == IW'(i)) rdata = regs[i];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_o[8*g +: 8] = regs[g];
  end

  assign sda_oe = (st == ACK) || (st == TX && !txsr[7]);

endmodule

module smb_cfg_slave_chk #(
  parameter int NREG = 7,
  parameter int IW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              sda_oe,
  input logic [NREG*8-1:0] cfg_o,
  input logic [IW-1:0]     widx
);
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_cfg_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> !scl_s);

  p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  p_widx_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    widx <= IW'(NREG + 2));

  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && !sda_oe && $past(scl_s) && $past(!sda_oe)) |=> (!sda_oe || !scl_s));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .sda_oe(sda_oe), .cfg_o(cfg_o), .widx(widx)
);

// File: tb/tb_smb_cfg_slave.sv
module tb_smb_cfg_slave;
  localparam int H = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_oe = 1'b0;
  logic sda_oe;
  logic [55:0] cfg_o;
  wire sda = !(m_oe || sda_oe);
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [7:0] model [7];

  always #2 clk = ~clk;

  smb_cfg_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
                     .sda_oe(sda_oe), .cfg_o(cfg_o));

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    m_oe = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    m_oe = 1'b1; tick(H);
    scl = 1'b0; tick(H/2);
  endtask

  task automatic stop_c();
    m_oe = 1'b1; tick(H);
    scl = 1'b1; tick(H);
    m_oe = 1'b0; tick(H);
  endtask

  task automatic wbit(input logic b);
    m_oe = !b; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(2);
  endtask

  task automatic rbit(output logic b);
    logic b1;
    m_oe = 1'b0; tick(H);
    scl = 1'b1; tick(H/4);
    b1 = sda; tick(H/2);
    b = sda;
    chk(b1 == b, "R10 sda steady while scl high", b, b1);
    tick(H/4);
    scl = 1'b0; tick(2);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(!ack);
  endtask

  task automatic chk_cfg(input string tag);
    for (int i = 0; i < 7; i++)
      chk(cfg_o[8*i +: 8] == model[i], tag, cfg_o[8*i +: 8], model[i]);
  endtask

  task automatic read_all(input string tag);
    logic a;
    logic [7:0] v;
    start_c();
    wbyte(8'hD3, a);
    chk(a, "R1 read address ack", a, 1);
    rbyte(1'b1, v);
    chk(v == 8'd7, "R6 byte count", v, 7);
    for (int i = 0; i < 7; i++) begin
      rbyte(i < 6, v);
      chk(v == model[i], tag, v, model[i]);
    end
    stop_c();
  endtask

  initial begin
    logic a, b;
    logic [7:0] v;
    for (int i = 0; i < 7; i++) model[i] = 8'(8'h11 * (i + 1));
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk_cfg("R8 reset defaults");
    chk(sda_oe == 1'b0, "R8 sda released after reset", sda_oe, 0);

    for (int k = 0; k < 10; k++) begin
      logic [7:0] av;
      logic expa;
      av = (k < 8) ? 8'(8'hD0 + k) : (k == 8 ? 8'h52 : 8'hA4);
      expa = (av == 8'hD2) || (av == 8'hD3);
      start_c();
      wbyte(av, a);
      chk(a == expa, "R1 address decode", a, expa);
      if (a && av[0]) begin
        rbyte(1'b0, v);
        chk(v == 8'd7, "R6 byte count", v, 7);
      end
      stop_c();
      chk_cfg("R1 no change from address only");
    end

    for (int k = 0; k < 10; k++) begin
      start_c();
      wbyte(8'hD2, a);
      chk(a, "R1 write address ack", a, 1);
      wbyte(8'(k * 29 + 3), a);
      chk(a, "R2 command ack", a, 1);
      wbyte(8'(k * 61 + 9), a);
      chk(a, "R2 count ack", a, 1);
      if (k == 0) begin
        stop_c();
        chk_cfg("R2 header bytes discarded");
        continue;
      end
      for (int j = 0; j < k; j++) begin
        logic [7:0] d;
        d = 8'(k * 37 + j * 13 + 5);
        wbyte(d, a);
        if (j < 7) begin
          chk(a, "R3 data ack", a, 1);
          model[j] = d;
        end else begin
          chk(a, "R5 surplus data ack", a, 1);
        end
      end
      stop_c();
      chk_cfg(k < 7 ? "R4 partial write" : (k == 7 ? "R3 full write" : "R5 no wrap"));
      read_all("R6 readback");
    end

    start_c();
    wbyte(8'hD3, a);
    rbyte(1'b1, v);
    chk(v == 8'd7, "R7 count before nack", v, 7);
    rbyte(1'b0, v);
    chk(v == model[0], "R7 reg0 before nack", v, model[0]);
    for (int i = 0; i < 9; i++) begin
      rbit(b);
      chk(b == 1'b1, "R7 sda released after nack", b, 1);
    end
    stop_c();
    read_all("R7 read after nack");

    start_c();
    wbyte(8'hD2, a);
    wbyte(8'h00, a);
    wbyte(8'h07, a);
    wbyte(8'hA5, a);
    chk(a, "R9 data ack", a, 1);
    model[0] = 8'hA5;
    wbit(1'b0);
    wbit(1'b1);
    start_c();
    wbyte(8'hD3, a);
    chk(a, "R9 address after repeated start", a, 1);
    rbyte(1'b1, v);
    chk(v == 8'd7, "R9 count after repeated start", v, 7);
    rbyte(1'b0, v);
    chk(v == 8'hA5, "R9 reg0 after repeated start", v, 8'hA5);
    stop_c();
    chk_cfg("R9 bank after aborted write");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule